// File: doc/BRIEF.md
# Power-Down Pin Control and Interrupt Unit

This block watches an external power-down pin (low means power down). It keeps one sticky flag for each direction of change on the pin and raises a power interrupt when a flagged edge has its enable set. Software reaches the unit through two 8-bit registers. The status register holds the flags, the interrupt, the live pin level, an ADC power kill bit and a soft power bit. The mode register holds the two edge enables and the hardware/software power mode selector.

In hardware mode the synchronized pin level drives the analog power control directly, and the soft power bit cannot be written. In software mode the pin only produces edge events, and analog power follows the last value written to the soft power bit. The ADC power output follows the analog power output unless the ADC kill bit is set. The chip's global status write path gives the unit a hold-clear control that keeps both edge flags at zero while it is active. A master interrupt enable bit gates the external interrupt output.

Top module: `pwrpin_ctrl`

## Requirements
- R1: After synchronous reset with the pin held high, the status register reads 0x09, the mode register reads 0x00, and both `analog_pwr_on` and `adc_pwr_on` are 1.
- R2: The pin passes through a two-flop synchronizer. Status bit 3 shows the pin level two clock edges after the pin changes.
- R3: Status bit 2 is a sticky flag. It is set on the third clock edge after a high-to-low pin change, whatever the enable settings are.
- R4: Status bit 1 is a sticky flag. It is set on the third clock edge after a low-to-high pin change, whatever the enable settings are.
- R5: The power interrupt (status bit 7 and `pwr_irq_gstat`) is 1 exactly when (status bit 2 AND mode bit 2) OR (status bit 1 AND mode bit 1). Clearing both enables drops it.
- R6: `irq_out` equals the power interrupt ANDed with `mie_pwr_en`.
- R7: Any write to the status register (address 0) clears both edge flags on that clock edge. If an edge is detected on the same edge as the write, the clear wins.
- R8: A global status write with `gstat_hold` = 1 clears both flags and keeps them cleared, recording no new edges, until a global status write with `gstat_hold` = 0.
- R9: With mode bit 0 = 0 (hardware mode), `analog_pwr_on` equals the synchronized pin level, status bit 0 reads that level, and writes to status bit 0 are ignored.
- R10: With mode bit 0 = 1 (software mode), `analog_pwr_on` and status bit 0 equal the last value written to status bit 0 while in software mode. This stored value resets to 0. Pin changes do not affect power.
- R11: Status bit 4 is read/write. When it is 1, `adc_pwr_on` is 0. When it is 0, `adc_pwr_on` equals `analog_pwr_on`.
- R12: Mode register (address 1) bits 2:0 are read/write, and bits 7:3 read 0. Status bits 6:5 read 0. Any other address reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| pin_pd_n | input | 1 | Asynchronous power-down pin, low means power down |
| reg_addr | input | 2 | Register address: 0 status, 1 mode |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| gstat_wr | input | 1 | Global status register write strobe |
| gstat_hold | input | 1 | Bit 3 of the global status write data (hold-clear) |
| mie_pwr_en | input | 1 | Bit 3 of the master interrupt enable register |
| pwr_irq_gstat | output | 1 | Power interrupt level for global status bit 3 |
| irq_out | output | 1 | External interrupt request |
| analog_pwr_on | output | 1 | Analog power on (1) or low power (0) |
| adc_pwr_on | output | 1 | ADC analog power on |

## Verification
The assertions check on every cycle that the flags stay set until a clearing event occurs. They also check that a status write or an active hold leaves both flags at zero, that the interrupt output needs both a flagged edge and the master enable, that the ADC kill bit forces the ADC power off, and that the soft bit does not move in hardware mode. Some behaviours only the bench scenarios can show: the exact synchronizer latency, the clear winning over a coincident edge, edges lost during the hold window, the soft bit value carried across a mode switch, and reserved bits reading zero. A cycle model in the bench compares every output against randomized pin, write and hold traffic.

// File: rtl/pwrpin_pkg.sv
// Package: bit positions and the mode register layout shared by the
// power-pin control unit, its sub-blocks and its checker.
package pwrpin_pkg;
    localparam int DATA_W      = 8;
    // status register bit positions
    localparam int ST_IRQ      = 7;
    localparam int ST_ADC_KILL = 4;
    localparam int ST_PIN      = 3;
    localparam int ST_FALL     = 2;
    localparam int ST_RISE     = 1;
    localparam int ST_SOFT     = 0;
    // mode register bit positions
    localparam int MD_FALL_EN  = 2;
    localparam int MD_RISE_EN  = 1;
    localparam int MD_SW       = 0;

    typedef struct packed {
        logic fall_en;
        logic rise_en;
        logic sw_mode;
    } pwr_mode_t;
endpackage

// File: rtl/pwrpin_sync_edge.sv
// Module: pwrpin_sync_edge
// Brings the asynchronous power-down pin into the clock domain through a
// STAGES-deep flop chain, then flags level changes by comparing the
// synchronized level with its value one clock earlier.
// Assumes STAGES >= 2 and that the pin sits at RST_LEVEL during reset.
module pwrpin_sync_edge #(
    parameter int   STAGES    = 2,
    parameter logic RST_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_level,
    output logic rise_pulse,
    output logic fall_pulse
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the pin through the synchronizer and remember the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= {STAGES{RST_LEVEL}};
            prev_q <= RST_LEVEL;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_async};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Derive the level and one-cycle edge pulses.
    always_comb begin
        pin_level  = sync_q[STAGES-1];
        rise_pulse = pin_level & ~prev_q;
        fall_pulse = ~pin_level & prev_q;
    end
endmodule

// File: rtl/pwrpin_edge_flags.sv
// Module: pwrpin_edge_flags
// Keeps the sticky rise/fall flags and the global-status hold-clear state.
// A status write, a global write with the hold bit set, or a hold that is
// already active clears both flags; the clear beats a coincident edge.
module pwrpin_edge_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_pulse,
    input  logic fall_pulse,
    input  logic stat_wr,
    input  logic gstat_wr,
    input  logic gstat_hold,
    output logic rise_flag,
    output logic fall_flag,
    output logic hold_q
);
    logic clr_now;

    // Combine every clear source into one term.
    always_comb begin
        clr_now = stat_wr | (gstat_wr & gstat_hold) | hold_q;
    end

    // Latch the hold-clear state on each global status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else if (gstat_wr) begin
            hold_q <= gstat_hold;
        end
    end

    // Update the sticky flags; clearing has priority over setting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_flag <= 1'b0;
            fall_flag <= 1'b0;
        end else if (clr_now) begin
            rise_flag <= 1'b0;
            fall_flag <= 1'b0;
        end else begin
            rise_flag <= rise_flag | rise_pulse;
            fall_flag <= fall_flag | fall_pulse;
        end
    end
endmodule

// File: rtl/pwrpin_regs.sv
// Module: pwrpin_regs
// Holds the mode register, the ADC kill bit and the soft power bit. It
// decodes writes, forms the power interrupt and drives the read mux.
// The soft power bit accepts writes only in software mode.
module pwrpin_regs
    import pwrpin_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int STAT_ADDR = 0,
    parameter int MODE_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pin_level,
    input  logic              rise_flag,
    input  logic              fall_flag,
    output logic              stat_wr,
    output pwr_mode_t         mode_q,
    output logic              soft_q,
    output logic              adc_kill_q,
    output logic              pwr_irq,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(MODE_ADDR);

    logic mode_wr;
    logic unused_wbits;

    // Decode the write strobes.
    always_comb begin
        stat_wr      = wr && (addr == A_STAT);
        mode_wr      = wr && (addr == A_MODE);
        unused_wbits = ^{wdata[DATA_W-1:ST_ADC_KILL+1], wdata[ST_PIN:ST_RISE]};
    end

    // Mode register: three live bits, all cleared by master reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_wr) begin
            mode_q.fall_en <= wdata[MD_FALL_EN];
            mode_q.rise_en <= wdata[MD_RISE_EN];
            mode_q.sw_mode <= wdata[MD_SW];
        end
    end

    // ADC kill bit: written on every status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adc_kill_q <= 1'b0;
        end else if (stat_wr) begin
            adc_kill_q <= wdata[ST_ADC_KILL];
        end
    end

    // Soft power bit: written only while software mode is selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_q <= 1'b0;
        end else if (stat_wr && mode_q.sw_mode) begin
            soft_q <= wdata[ST_SOFT];
        end
    end

    // Power interrupt: an enabled, recorded edge.
    always_comb begin
        pwr_irq = (fall_flag & mode_q.fall_en) | (rise_flag & mode_q.rise_en);
    end

    // Read mux; reserved bits and unmapped addresses return zero.
    always_comb begin
        rdata = '0;
        if (addr == A_STAT) begin
            rdata[ST_IRQ]      = pwr_irq;
            rdata[ST_ADC_KILL] = adc_kill_q;
            rdata[ST_PIN]      = pin_level;
            rdata[ST_FALL]     = fall_flag;
            rdata[ST_RISE]     = rise_flag;
            rdata[ST_SOFT]     = mode_q.sw_mode ? soft_q : pin_level;
        end else if (addr == A_MODE) begin
            rdata[MD_FALL_EN]  = mode_q.fall_en;
            rdata[MD_RISE_EN]  = mode_q.rise_en;
            rdata[MD_SW]       = mode_q.sw_mode;
        end
    end
endmodule

// File: rtl/pwrpin_ctrl.sv
// Module: pwrpin_ctrl (top)
// Power-down pin control and interrupt unit. Synchronizes the pin, keeps
// the sticky edge flags, holds the two registers and chooses the analog
// power source (pin level or soft bit). The ADC power is gated by its kill bit.
// Assumes one clock domain and the pin high during reset.
module pwrpin_ctrl
    import pwrpin_pkg::*;
#(
    parameter int   ADDR_W      = 2,
    parameter int   STAT_ADDR   = 0,
    parameter int   MODE_ADDR   = 1,
    parameter int   SYNC_STAGES = 2,
    parameter logic PIN_RST_LVL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_pd_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              gstat_wr,
    input  logic              gstat_hold,
    input  logic              mie_pwr_en,
    output logic              pwr_irq_gstat,
    output logic              irq_out,
    output logic              analog_pwr_on,
    output logic              adc_pwr_on
);
    logic      pin_level;
    logic      rise_pulse;
    logic      fall_pulse;
    logic      rise_flag;
    logic      fall_flag;
    logic      hold_q;
    logic      stat_wr;
    pwr_mode_t mode_q;
    logic      sw_mode;
    logic      soft_q;
    logic      adc_dis;
    logic      pwr_irq;

    pwrpin_sync_edge #(
        .STAGES    (SYNC_STAGES),
        .RST_LEVEL (PIN_RST_LVL)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_async  (pin_pd_n),
        .pin_level  (pin_level),
        .rise_pulse (rise_pulse),
        .fall_pulse (fall_pulse)
    );

    pwrpin_edge_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_pulse (rise_pulse),
        .fall_pulse (fall_pulse),
        .stat_wr    (stat_wr),
        .gstat_wr   (gstat_wr),
        .gstat_hold (gstat_hold),
        .rise_flag  (rise_flag),
        .fall_flag  (fall_flag),
        .hold_q     (hold_q)
    );

    pwrpin_regs #(
        .ADDR_W    (ADDR_W),
        .STAT_ADDR (STAT_ADDR),
        .MODE_ADDR (MODE_ADDR)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (reg_addr),
        .wr         (reg_wr),
        .wdata      (reg_wdata),
        .pin_level  (pin_level),
        .rise_flag  (rise_flag),
        .fall_flag  (fall_flag),
        .stat_wr    (stat_wr),
        .mode_q     (mode_q),
        .soft_q     (soft_q),
        .adc_kill_q (adc_dis),
        .pwr_irq    (pwr_irq),
        .rdata      (reg_rdata)
    );

    // Pick the power source and gate the interrupt and ADC outputs.
    always_comb begin
        sw_mode       = mode_q.sw_mode;
        analog_pwr_on = sw_mode ? soft_q : pin_level;
        adc_pwr_on    = analog_pwr_on & ~adc_dis;
        pwr_irq_gstat = pwr_irq;
        irq_out       = pwr_irq & mie_pwr_en;
    end
endmodule

// File: rtl/pwrpin_ctrl_checker.sv
// Module: pwrpin_ctrl_checker
// Concurrent properties for pwrpin_ctrl, attached by the bind below.
module pwrpin_ctrl_checker #(
    parameter int ADDR_W    = 2,
    parameter int STAT_ADDR = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              gstat_wr,
    input logic              gstat_hold,
    input logic              mie_pwr_en,
    input logic              pwr_irq_gstat,
    input logic              irq_out,
    input logic              adc_pwr_on,
    input logic              fall_flag,
    input logic              rise_flag,
    input logic              hold_q,
    input logic              sw_mode,
    input logic              soft_q,
    input logic              adc_dis
);
    logic st_write;
    logic any_clear;

    // Clear conditions rebuilt from the ports.
    always_comb begin
        st_write  = reg_wr && (reg_addr == ADDR_W'(STAT_ADDR));
        any_clear = st_write || (gstat_wr && gstat_hold) || hold_q;
    end

    p_fall_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_flag && !any_clear) |=> fall_flag);

    p_rise_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_flag && !any_clear) |=> rise_flag);

    p_irq_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_irq_gstat |-> (fall_flag || rise_flag));

    p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (pwr_irq_gstat && mie_pwr_en));

    p_stat_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_write |=> (!fall_flag && !rise_flag));

    p_hold_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> (!fall_flag && !rise_flag));

    p_soft_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_write && !sw_mode) |=> $stable(soft_q));

    p_adc_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        adc_dis |-> !adc_pwr_on);
endmodule

bind pwrpin_ctrl pwrpin_ctrl_checker #(
    .ADDR_W    (ADDR_W),
    .STAT_ADDR (STAT_ADDR)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_addr      (reg_addr),
    .reg_wr        (reg_wr),
    .gstat_wr      (gstat_wr),
    .gstat_hold    (gstat_hold),
    .mie_pwr_en    (mie_pwr_en),
    .pwr_irq_gstat (pwr_irq_gstat),
    .irq_out       (irq_out),
    .adc_pwr_on    (adc_pwr_on),
    .fall_flag     (fall_flag),
    .rise_flag     (rise_flag),
    .hold_q        (hold_q),
    .sw_mode       (sw_mode),
    .soft_q        (soft_q),
    .adc_dis       (adc_dis)
);

// File: tb/pwrpin_ctrl_test.sv
`timescale 1ns/1ps
// Bench for pwrpin_ctrl: directed corner cases with fixed expected values,
// then seeded random traffic compared against a cycle model built from
// the requirements.
module pwrpin_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_pd_n = 1'b1;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       gstat_wr = 1'b0;
    logic       gstat_hold = 1'b0;
    logic       mie_pwr_en = 1'b0;
    logic       pwr_irq_gstat, irq_out, analog_pwr_on, adc_pwr_on;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwrpin_ctrl uut (
        .clk(clk), .rst_n(rst_n), .pin_pd_n(pin_pd_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .gstat_wr(gstat_wr), .gstat_hold(gstat_hold),
        .mie_pwr_en(mie_pwr_en), .pwr_irq_gstat(pwr_irq_gstat),
        .irq_out(irq_out), .analog_pwr_on(analog_pwr_on),
        .adc_pwr_on(adc_pwr_on)
    );

    // Reference model state.
    logic m_s1, m_s2, m_s3, m_fall, m_rise, m_hold, m_soft, m_adc;
    logic [2:0] m_mode;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 1'b1; m_s2 <= 1'b1; m_s3 <= 1'b1;
            m_fall <= 1'b0; m_rise <= 1'b0; m_hold <= 1'b0;
            m_soft <= 1'b0; m_adc <= 1'b0; m_mode <= 3'b000;
        end else begin
            m_s1 <= pin_pd_n; m_s2 <= m_s1; m_s3 <= m_s2;
            if ((reg_wr && reg_addr == 2'd0) || (gstat_wr && gstat_hold) || m_hold) begin
                m_fall <= 1'b0; m_rise <= 1'b0;
            end else begin
                m_fall <= m_fall | (m_s3 & ~m_s2);
                m_rise <= m_rise | (~m_s3 & m_s2);
            end
            if (gstat_wr) m_hold <= gstat_hold;
            if (reg_wr && reg_addr == 2'd1) m_mode <= reg_wdata[2:0];
            if (reg_wr && reg_addr == 2'd0) begin
                m_adc <= reg_wdata[4];
                if (m_mode[0]) m_soft <= reg_wdata[0];
            end
        end
    end

    function automatic logic f_irq();
        return (m_fall & m_mode[2]) | (m_rise & m_mode[1]);
    endfunction

    function automatic logic f_analog();
        return m_mode[0] ? m_soft : m_s2;
    endfunction

    function automatic logic [7:0] f_rdata(input logic [1:0] a);
        if (a == 2'd0)
            return {f_irq(), 2'b00, m_adc, m_s2, m_fall, m_rise, f_analog()};
        else if (a == 2'd1)
            return {5'b0, m_mode};
        return 8'h00;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic gwrite(input logic h);
        gstat_hold = h; gstat_wr = 1'b1;
        tick(1);
        gstat_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5eed_1234));
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        rd(2'd0, d); check("R1 status", d, 8'h09);
        rd(2'd1, d); check("R1 mode", d, 8'h00);
        check("R1 analog", {7'b0, analog_pwr_on}, 8'h01);
        check("R1 adc", {7'b0, adc_pwr_on}, 8'h01);

        // R2 / R3 / R9 falling edge in hardware mode
        pin_pd_n = 1'b0;
        tick(1); rd(2'd0, d); check("R2 level after one edge", d & 8'h08, 8'h08);
        tick(1); rd(2'd0, d); check("R2 level after two edges", d, 8'h00);
        check("R9 analog follows pin", {7'b0, analog_pwr_on}, 8'h00);
        tick(1); rd(2'd0, d); check("R3 fall flag unmasked", d, 8'h04);

        // R5 / R6 enable falling interrupt, gate with master enable
        wr_reg(2'd1, 8'h04);
        rd(2'd0, d); check("R5 irq bit", d, 8'h84);
        check("R5 gstat out", {7'b0, pwr_irq_gstat}, 8'h01);
        check("R6 gated off", {7'b0, irq_out}, 8'h00);
        mie_pwr_en = 1'b1; #1;
        check("R6 gated on", {7'b0, irq_out}, 8'h01);

        // R7 status write clears flags
        wr_reg(2'd0, 8'h00);
        rd(2'd0, d); check("R7 write clears", d, 8'h00);
        check("R7 irq dropped", {7'b0, irq_out}, 8'h00);

        // R7 clear wins over a coincident rising edge
        pin_pd_n = 1'b1;
        tick(2);
        wr_reg(2'd0, 8'h00);
        tick(1);
        rd(2'd0, d); check("R7 clear beats edge", d, 8'h09);

        // R8 hold-clear window
        gwrite(1'b1);
        pin_pd_n = 1'b0; tick(4);
        rd(2'd0, d); check("R8 held clear", d, 8'h00);
        gwrite(1'b0);
        pin_pd_n = 1'b1; tick(4);
        rd(2'd0, d); check("R4 rise after release", d, 8'h0B);
        wr_reg(2'd0, 8'h00);

        // R9 soft write ignored in hardware mode, R10 software mode
        wr_reg(2'd0, 8'h00);
        rd(2'd0, d); check("R9 bit0 is pin", d, 8'h09);
        check("R9 analog on", {7'b0, analog_pwr_on}, 8'h01);
        wr_reg(2'd1, 8'h01);
        rd(2'd0, d); check("R10 soft reset value", d, 8'h08);
        check("R10 analog off", {7'b0, analog_pwr_on}, 8'h00);
        wr_reg(2'd0, 8'h01);
        check("R10 analog on", {7'b0, analog_pwr_on}, 8'h01);
        pin_pd_n = 1'b0; tick(4);
        check("R10 pin ignored", {7'b0, analog_pwr_on}, 8'h01);
        rd(2'd0, d); check("R10 R3 status", d, 8'h05);

        // R11 ADC kill
        wr_reg(2'd0, 8'h11);
        check("R11 adc off", {7'b0, adc_pwr_on}, 8'h00);
        check("R11 analog stays", {7'b0, analog_pwr_on}, 8'h01);
        rd(2'd0, d); check("R11 readback", d, 8'h11);
        wr_reg(2'd0, 8'h01);
        check("R11 adc back on", {7'b0, adc_pwr_on}, 8'h01);

        // R12 reserved bits and unmapped address
        wr_reg(2'd1, 8'hFF);
        rd(2'd1, d); check("R12 mode reserved", d, 8'h07);
        rd(2'd2, d); check("R12 unmapped", d, 8'h00);
        wr_reg(2'd0, 8'hFF);
        rd(2'd0, d); check("R12 status reserved", d, 8'h11);
        wr_reg(2'd0, 8'h01);

        // R5 rising enable, then clearing enables drops irq
        wr_reg(2'd1, 8'h02);
        pin_pd_n = 1'b1; tick(4);
        rd(2'd0, d); check("R5 rise irq", d, 8'h8B);
        wr_reg(2'd1, 8'h00);
        rd(2'd0, d); check("R5 enables cleared", d, 8'h0B);

        // Random phase against the model
        for (int i = 0; i < 600; i++) begin
            #1;
            check("R3 R4 R12 rdata", reg_rdata, f_rdata(reg_addr));
            check("R9 R10 analog", {7'b0, analog_pwr_on}, {7'b0, f_analog()});
            check("R11 adc", {7'b0, adc_pwr_on}, {7'b0, f_analog() & ~m_adc});
            check("R5 gstat", {7'b0, pwr_irq_gstat}, {7'b0, f_irq()});
            check("R6 irq_out", {7'b0, irq_out}, {7'b0, f_irq() & mie_pwr_en});
            tick(1);
            if ($urandom_range(3) == 0) pin_pd_n = ~pin_pd_n;
            reg_addr   = 2'($urandom_range(3));
            reg_wr     = ($urandom_range(5) == 0);
            reg_wdata  = 8'($urandom);
            gstat_wr   = ($urandom_range(19) == 0);
            gstat_hold = ($urandom_range(1) == 0);
            mie_pwr_en = ($urandom_range(1) == 0);
        end
        finish_run();
    end
endmodule